// File: doc/BRIEF.md
# Configurable Watchdog Interval Timer

This block supervises a system from a slow periodic tick of about 10 kHz, which arrives as a one-clock enable. A selectable prescaler divides the tick. A six-bit stage then counts 64 divided periods, and that count is one time-out interval. When an interval ends, the block latches a sticky time-out flag and emits a one-cycle wake-up pulse. It also drives an interrupt request if software has enabled one.

A four-bit configuration code picks one of three behaviours:

- **Periodic timer.** Code `4'hF` makes the block a software-run periodic timer that never requests a reset.
- **Pausing watchdog.** Code `4'h5` makes it a reset watchdog that freezes while the system is idle or powered down.
- **Running watchdog.** Any other code makes it a reset watchdog that keeps counting through those low-power states.

In either watchdog mode, a time-out starts a grace window of 64 undivided ticks. If software does not clear the block within that window, the block issues a one-cycle system reset request.

Software restarts the interval with a clear strobe. The clear also cancels any pending reset. A new prescale choice is taken up only when the counter restarts, either through a clear or through the wrap at a time-out, so a running interval is never cut short.

Top module: `wdt_interval_timer`

## Requirements
- R1: With `cfgCode` equal to 4'hF the block is a periodic timer and `sysResetReq` never asserts.
- R2: With `cfgCode` equal to 4'h5, ticks that arrive while `idleMode` or `powerDown` is high are not counted.
- R3: With any `cfgCode` other than 4'hF or 4'h5, counting continues while `idleMode` or `powerDown` is high.
- R4: `scaleSel` values 0..7 select divide ratios 1, 4, 8, 16, 32, 64, 128 and 256. The interval is 64 times the ratio in counted ticks.
- R5: One cycle after the clock edge that counts the last tick of an interval, `wakePulse` is high for exactly one cycle and `timeoutFlag` is set. After reset every output is low.
- R6: `irq` is high exactly while `timeoutFlag` and `intEnable` are both high.
- R7: In the two watchdog modes, `sysResetReq` pulses for one cycle 64 counted ticks after the `wakePulse` of the time-out that armed it.
- R8: `swClear` zeroes the prescaler and the interval counter, and it cancels a pending reset request.
- R9: In timer mode, `runBit` low stops counting. Intervals repeat back to back while it is high.
- R10: `timeoutFlag` stays set until a `flagClear` strobe clears it.
- R11: A change on `scaleSel` takes effect only at the next `swClear` or interval wrap.
- R12: While `tickEn` is low, nothing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable per slow oscillator tick |
| cfgCode | input | 4 | Behaviour select: F timer, 5 pausing watchdog, others running watchdog |
| scaleSel | input | 3 | Prescale select |
| runBit | input | 1 | Run control in timer mode |
| swClear | input | 1 | Restart the interval and cancel a pending reset |
| flagClear | input | 1 | Write-one-to-clear strobe for the time-out flag |
| intEnable | input | 1 | Interrupt enable |
| idleMode | input | 1 | System is idle |
| powerDown | input | 1 | System is powered down |
| timeoutFlag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Interrupt request |
| wakePulse | output | 1 | One-cycle wake-up at each time-out |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The properties assume that `cfgCode` and `scaleSel` change only in the same cycle as a `swClear` strobe. Under that assumption, a behaviour switch can never meet a half-finished grace window or a stale prescale setting. The stimulus holds to this by changing both fields only inside its clear routine, which raises `swClear` on the same falling edge. The properties also assume that intervals are longer than one cycle. This holds because every ratio gives at least 64 counted ticks between expiries, so each wake and reset pulse is followed by a quiet cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER    = 2'd0,
    MODE_RST_HOLD = 2'd1,
    MODE_RST_RUN  = 2'd2
  } wdtMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic clearAll;
    logic armEnable;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int MAIN_W  = 6,
  parameter int DELAY_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [SEL_W-1:0] scaleSel,
  output logic             expire,
  output logic             delayDone
);
  localparam int PRE_W = 2 ** SEL_W;

  logic [SEL_W-1:0]   activeSel;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preTerm;
  logic [MAIN_W-1:0]  mainCnt;
  logic [DELAY_W-1:0] delayCnt;
  logic               armed;
  logic               divTick;

  // ratio 1 for select 0, otherwise 2^(sel+1): terminal is a low-bit mask
  always_comb begin
    preTerm = '0;
    for (int b = 0; b < PRE_W; b++) begin
      preTerm[b] = (activeSel != '0) && (b <= int'(activeSel));
    end
  end

  assign divTick   = strobe.countEn && (preCnt == preTerm);
  assign expire    = divTick && (&mainCnt) && !strobe.clearAll;
  assign delayDone = armed && strobe.countEn && (&delayCnt) && !strobe.clearAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel <= '0;
      preCnt    <= '0;
      mainCnt   <= '0;
      delayCnt  <= '0;
      armed     <= 1'b0;
    end else if (strobe.clearAll) begin
      activeSel <= scaleSel;
      preCnt    <= '0;
      mainCnt   <= '0;
      delayCnt  <= '0;
      armed     <= 1'b0;
    end else begin
      if (strobe.countEn) begin
        if (divTick) begin
          preCnt  <= '0;
          mainCnt <= mainCnt + MAIN_W'(1);
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
      if (expire) begin
        activeSel <= scaleSel;
      end
      if (armed && strobe.countEn) begin
        if (&delayCnt) begin
          armed <= 1'b0;
        end else begin
          delayCnt <= delayCnt + DELAY_W'(1);
        end
      end
      if (expire && strobe.armEnable && !armed) begin
        armed    <= 1'b1;
        delayCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int CFG_W = 4,
  parameter logic [CFG_W-1:0] CODE_TIMER = 4'hF,
  parameter logic [CFG_W-1:0] CODE_HOLD  = 4'h5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [CFG_W-1:0] cfgCode,
  input  logic             runBit,
  input  logic             swClear,
  input  logic             flagClear,
  input  logic             intEnable,
  input  logic             idleMode,
  input  logic             powerDown,
  input  logic             expire,
  input  logic             delayDone,
  output wdtStrobe_t       strobe,
  output logic             timeoutFlag,
  output logic             irq,
  output logic             wakePulse,
  output logic             sysResetReq
);
  wdtMode_e mode;
  logic     activeNow;

  always_comb begin
    if (cfgCode == CODE_TIMER)     mode = MODE_TIMER;
    else if (cfgCode == CODE_HOLD) mode = MODE_RST_HOLD;
    else                           mode = MODE_RST_RUN;

    unique case (mode)
      MODE_TIMER:    activeNow = runBit;
      MODE_RST_HOLD: activeNow = !(idleMode || powerDown);
      default:       activeNow = 1'b1;
    endcase

    strobe.countEn   = tickEn && activeNow;
    strobe.clearAll  = swClear;
    strobe.armEnable = (mode != MODE_TIMER);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutFlag <= 1'b0;
      wakePulse   <= 1'b0;
      sysResetReq <= 1'b0;
    end else begin
      if (expire)         timeoutFlag <= 1'b1;
      else if (flagClear) timeoutFlag <= 1'b0;
      wakePulse   <= expire;
      sysResetReq <= delayDone;
    end
  end

  assign irq = timeoutFlag && intEnable;
endmodule

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer
  import wdt_pkg::*;
#(
  parameter int CFG_W   = 4,
  parameter int SEL_W   = 3,
  parameter int MAIN_W  = 6,
  parameter int DELAY_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [CFG_W-1:0] cfgCode,
  input  logic [SEL_W-1:0] scaleSel,
  input  logic             runBit,
  input  logic             swClear,
  input  logic             flagClear,
  input  logic             intEnable,
  input  logic             idleMode,
  input  logic             powerDown,
  output logic             timeoutFlag,
  output logic             irq,
  output logic             wakePulse,
  output logic             sysResetReq
);
  wdtStrobe_t strobe;
  logic       expire;
  logic       delayDone;

  wdt_control #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgCode(cfgCode),
    .runBit(runBit), .swClear(swClear), .flagClear(flagClear),
    .intEnable(intEnable), .idleMode(idleMode), .powerDown(powerDown),
    .expire(expire), .delayDone(delayDone), .strobe(strobe),
    .timeoutFlag(timeoutFlag), .irq(irq), .wakePulse(wakePulse),
    .sysResetReq(sysResetReq)
  );

  wdt_datapath #(.SEL_W(SEL_W), .MAIN_W(MAIN_W), .DELAY_W(DELAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scaleSel(scaleSel),
    .expire(expire), .delayDone(delayDone)
  );
endmodule

// File: rtl/wdt_interval_timer_chk.sv
module wdt_interval_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic [3:0] cfgCode,
  input logic       runBit,
  input logic       swClear,
  input logic       flagClear,
  input logic       intEnable,
  input logic       idleMode,
  input logic       powerDown,
  input logic       timeoutFlag,
  input logic       irq,
  input logic       wakePulse,
  input logic       sysResetReq
);
  p_timer_never_resets_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCode == 4'hF) |-> !sysResetReq);
  p_hold_in_lowpower_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCode == 4'h5 && (idleMode || powerDown)) |=> !wakePulse);
  p_wake_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> timeoutFlag);
  p_wake_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
  p_irq_on_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulse && intEnable) |-> irq);
  p_reset_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);
  p_clear_cancels_r8: assert property (@(posedge clk) disable iff (!rstN)
    swClear |=> (!wakePulse && !sysResetReq));
  p_run_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCode == 4'hF && !runBit) |=> !wakePulse);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagClear |=> (!timeoutFlag || wakePulse));
  p_no_tick_r12: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (!wakePulse && !sysResetReq));
endmodule

bind wdt_interval_timer wdt_interval_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgCode(cfgCode),
  .runBit(runBit), .swClear(swClear), .flagClear(flagClear),
  .intEnable(intEnable), .idleMode(idleMode), .powerDown(powerDown),
  .timeoutFlag(timeoutFlag), .irq(irq), .wakePulse(wakePulse),
  .sysResetReq(sysResetReq)
);

// File: tb/wdt_interval_timer_test.sv
`timescale 1ns/1ps
module wdt_interval_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic [3:0] cfgCode = 4'hF;
  logic [2:0] scaleSel = 3'd0;
  logic runBit = 1'b1, swClear = 1'b0, flagClear = 1'b0, intEnable = 1'b0;
  logic idleMode = 1'b0, powerDown = 1'b0;
  logic timeoutFlag, irq, wakePulse, sysResetReq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  wdt_interval_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgCode(cfgCode),
    .scaleSel(scaleSel), .runBit(runBit), .swClear(swClear),
    .flagClear(flagClear), .intEnable(intEnable), .idleMode(idleMode),
    .powerDown(powerDown), .timeoutFlag(timeoutFlag), .irq(irq),
    .wakePulse(wakePulse), .sysResetReq(sysResetReq)
  );

  typedef struct packed {
    logic [3:0]  cfg;
    logic [2:0]  sel;
    logic [31:0] ticks;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{4'hF, 3'd0, 32'd64},    '{4'hF, 3'd1, 32'd256},
    '{4'hF, 3'd2, 32'd512},   '{4'hF, 3'd3, 32'd1024},
    '{4'hF, 3'd4, 32'd2048},  '{4'hF, 3'd5, 32'd4096},
    '{4'hF, 3'd6, 32'd8192},  '{4'hF, 3'd7, 32'd16384},
    '{4'h0, 3'd0, 32'd64},    '{4'h5, 3'd1, 32'd256},
    '{4'hA, 3'd2, 32'd512}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doClear(input logic [3:0] cfg, input logic [2:0] sel);
    @(negedge clk);
    cfgCode = cfg; scaleSel = sel; swClear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    swClear = 1'b0;
  endtask

  task automatic doFlagClear();
    @(negedge clk);
    flagClear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flagClear = 1'b0;
  endtask

  // kind: 0 none, 1 idle, 2 power-down, 3 tick off, 4 run off
  task automatic runUntilWake(input int limit, input int gFrom, input int gTo,
                              input int kind, output int n);
    n = 0;
    do begin
      idleMode  = (kind == 1) && (n >= gFrom) && (n < gTo);
      powerDown = (kind == 2) && (n >= gFrom) && (n < gTo);
      tickEn    = !((kind == 3) && (n >= gFrom) && (n < gTo));
      runBit    = !((kind == 4) && (n >= gFrom) && (n < gTo));
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!wakePulse && n < limit);
    idleMode = 1'b0; powerDown = 1'b0; tickEn = 1'b1; runBit = 1'b1;
  endtask

  task automatic watch(input int cycles, output int wakes, output int resets);
    wakes = 0; resets = 0;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (wakePulse) wakes++;
      if (sysResetReq) resets++;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int n, w, r;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 reset outputs", {timeoutFlag, irq, wakePulse, sysResetReq}, 0);
    rstN = 1'b1;

    // vector table: R4 ratios, R1/R2/R3 modes, R6 irq gating, R10 clear
    for (int i = 0; i < NVEC; i++) begin
      intEnable = i[0];
      doClear(VEC[i].cfg, VEC[i].sel);
      runUntilWake(40000, 0, 0, 0, n);
      check($sformatf("R4 interval vec %0d", i), n, int'(VEC[i].ticks));
      check("R5 flag at wake", int'(timeoutFlag), 1);
      check("R6 irq gating", int'(irq), i[0]);
      @(negedge clk);
      check("R5 wake one cycle", int'(wakePulse), 0);
      doFlagClear();
      check("R10 flag cleared", int'(timeoutFlag), 0);
      check("R6 irq after clear", int'(irq), 0);
    end
    intEnable = 1'b1;

    // R9 run gate, then periodic repeat; R1 no reset; R10 sticky
    doClear(4'hF, 3'd0);
    runUntilWake(1000, 20, 70, 4, n);
    check("R9 run gated interval", n, 114);
    watch(80, w, r);
    check("R9 periodic wake", w, 1);
    check("R1 timer never resets", r, 0);
    check("R10 flag sticky", int'(timeoutFlag), 1);
    doFlagClear();

    // R2 pausing watchdog
    doClear(4'h5, 3'd0);
    runUntilWake(1000, 20, 50, 1, n);
    check("R2 idle pauses", n, 94);
    doClear(4'h5, 3'd0);
    runUntilWake(1000, 20, 50, 2, n);
    check("R2 power-down pauses", n, 94);

    // R3 running watchdog
    doClear(4'h0, 3'd0);
    runUntilWake(1000, 20, 50, 1, n);
    check("R3 idle keeps counting", n, 64);
    doClear(4'h3, 3'd0);
    runUntilWake(1000, 20, 50, 2, n);
    check("R3 power-down keeps counting", n, 64);

    // R12 tick gating
    doClear(4'hF, 3'd0);
    runUntilWake(1000, 10, 60, 3, n);
    check("R12 no tick no count", n, 114);

    // R7 reset delay
    doClear(4'h0, 3'd0);
    runUntilWake(1000, 0, 0, 0, n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!sysResetReq && n < 500);
    check("R7 reset delay", n, 64);
    @(negedge clk);
    check("R7 reset one cycle", int'(sysResetReq), 0);

    // R8 clear restarts counting and cancels pending reset
    doClear(4'h0, 3'd0);
    runUntilWake(30, 0, 0, 0, n);
    doClear(4'h0, 3'd0);
    runUntilWake(1000, 0, 0, 0, n);
    check("R8 clear restarts interval", n, 64);
    repeat (10) @(negedge clk);
    doClear(4'h0, 3'd0);
    watch(100, w, r);
    check("R8 reset cancelled", r, 0);

    // R11 prescale change deferred to wrap
    doClear(4'hF, 3'd0);
    runUntilWake(10, 0, 0, 0, n);
    scaleSel = 3'd1;
    runUntilWake(1000, 0, 0, 0, n);
    check("R11 old ratio kept", n, 54);
    runUntilWake(1000, 0, 0, 0, n);
    check("R11 new ratio after wrap", n, 256);

    summary();
  end
endmodule